// File: doc/BRIEF.md
# PCM Peak Level Meter

This block watches a stream of linear PCM samples arriving once per 125 µs frame and reports how loud the stream is. A programmable count sets a measurement window of N frames. Over each window the block tracks the largest magnitude seen. When the window closes it latches that peak into a 16-bit result and raises a ready flag. A count of zero turns windowing off: every frame's raw sample is copied straight into the result.

The result is read as two bytes. The low byte carries the ready flag in its bit 0, so the result's least significant bit is not reported. The high byte is read after the low byte. A low-byte read captures the high half, so the two bytes form one coherent pair even if a new window closes between the two reads. Reading the high byte clears the ready flag.

Top module: `pcm_level_meter`

## Requirements
- R1: After reset, `lowByte` and `highByte` are both 0 and the ready flag is clear.
- R2: A `countWr` pulse loads `countData` as the window length and restarts the window: the frame count and the running peak return to zero. A `frameTick` in the same cycle is ignored. The result bytes and the ready flag are untouched.
- R3: With a window length N from 1 to 255, the result is latched on the Nth accepted `frameTick` since the window started. The next window then starts empty.
- R4: The windowed result is the largest two's-complement magnitude of `sampleIn` seen over the window, with -32768 giving 0x8000. Result bits 15:8 form the high half. Result bits 7:1 appear on `lowByte[7:1]`.
- R5: With a window length of 0, every `frameTick` copies the raw `sampleIn` into the result. `lowByte[7:1]` shows `sampleIn[7:1]`, and the ready flag is set.
- R6: `lowByte[0]` is the ready flag. It goes to 1 in the cycle after any result is latched.
- R7: A `readHigh` pulse clears the ready flag in the next cycle. If a result is latched in the same cycle, the latch wins and the flag stays set.
- R8: `highByte` shows the high half of the result as it stood when the most recent `readLow` pulse was taken. Between `readLow` pulses it holds its value.
- R9: A window that closes before the previous result was read overwrites that result, and the ready flag stays set.
- R10: In cycles without `frameTick` or `countWr`, the result bytes and the window progress do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | One-cycle strobe per 125 µs frame; `sampleIn` is valid with it |
| sampleIn | input | 16 | Linear two's-complement PCM sample |
| countWr | input | 1 | Write strobe for the window length |
| countData | input | 8 | New window length in frames (0 = pass-through) |
| readLow | input | 1 | Host read strobe for the low result byte |
| readHigh | input | 1 | Host read strobe for the high result byte |
| lowByte | output | 8 | Result bits 7:1 above the ready flag in bit 0 |
| highByte | output | 8 | High result half captured at the last low read |

## Verification
The hardest cases to reach from the ports are the ones where events fall in the same cycle. One is a window closing in the very cycle the host reads the high byte. Another is a count write landing on a frame tick. A third is a window closing between the low and high reads. Random stimulus with short windows of one to six frames makes these collisions frequent. Directed sequences also force each one on purpose, together with the -32768 sample and the full 255-frame window.

// File: rtl/pcm_level_meter_pkg.sv
package pcm_level_meter_pkg;
  typedef struct packed {
    logic accClear;
    logic accUpdate;
    logic latchPeak;
    logic latchRaw;
    logic snapHigh;
  } meterCtl_t;
endpackage

// File: rtl/pcm_level_meter_ctrl.sv
module pcm_level_meter_ctrl
  import pcm_level_meter_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameTick,
  input  logic               countWr,
  input  logic [COUNT_W-1:0] countData,
  input  logic               readLow,
  input  logic               readHigh,
  output meterCtl_t          ctl,
  output logic               ready
);
  logic [COUNT_W-1:0] countQ;
  logic [COUNT_W-1:0] frameCnt;
  logic               tickOk;
  logic               lastFrame;

  assign tickOk    = frameTick && !countWr;
  assign lastFrame = (countQ != '0) && (frameCnt == countQ - 1'b1);

  always_comb begin
    ctl.latchRaw  = tickOk && (countQ == '0);
    ctl.accUpdate = tickOk && (countQ != '0);
    ctl.latchPeak = ctl.accUpdate && lastFrame;
    ctl.accClear  = countWr || ctl.latchPeak;
    ctl.snapHigh  = readLow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ   <= '0;
      frameCnt <= '0;
      ready    <= 1'b0;
    end else begin
      if (countWr) begin
        countQ   <= countData;
        frameCnt <= '0;
      end else if (ctl.latchPeak) begin
        frameCnt <= '0;
      end else if (ctl.accUpdate) begin
        frameCnt <= frameCnt + 1'b1;
      end
      if (ctl.latchPeak || ctl.latchRaw) ready <= 1'b1;
      else if (readHigh)                 ready <= 1'b0;
    end
  end

  // R3: the frame count never reaches the window length
  a_r3_cnt_in_window: assert property (@(posedge clk) disable iff (!rstN)
    (countQ != '0) |-> (frameCnt < countQ));
  // R2: a count write restarts the window
  a_r2_restart: assert property (@(posedge clk) disable iff (!rstN)
    countWr |=> (frameCnt == '0));
  // R7: a high read with no latch clears ready
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    (readHigh && !ctl.latchPeak && !ctl.latchRaw) |=> !ready);
  // R6: any latch sets ready
  a_r6_set: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.latchPeak || ctl.latchRaw) |=> ready);
endmodule

// File: rtl/pcm_level_meter_dp.sv
module pcm_level_meter_dp
  import pcm_level_meter_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  meterCtl_t           ctl,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] resultQ,
  output logic [SAMPLE_W/2-1:0] holdQ
);
  localparam int HALF = SAMPLE_W / 2;

  logic [SAMPLE_W-1:0] peakQ;
  logic [SAMPLE_W-1:0] absVal;
  logic [SAMPLE_W-1:0] peakNext;

  assign absVal   = sampleIn[SAMPLE_W-1] ? (~sampleIn + 1'b1) : sampleIn;
  assign peakNext = (absVal > peakQ) ? absVal : peakQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      peakQ   <= '0;
      resultQ <= '0;
      holdQ   <= '0;
    end else begin
      if (ctl.accClear)       peakQ <= '0;
      else if (ctl.accUpdate) peakQ <= peakNext;
      if (ctl.latchPeak)      resultQ <= peakNext;
      else if (ctl.latchRaw)  resultQ <= sampleIn;
      if (ctl.snapHigh)       holdQ <= resultQ[SAMPLE_W-1:HALF];
    end
  end

  // R4: a magnitude never exceeds the most negative sample's magnitude
  a_r4_peak_bound: assert property (@(posedge clk) disable iff (!rstN)
    peakQ <= (SAMPLE_W'(1) << (SAMPLE_W-1)));
  // R8: the high hold only moves on a low read
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.snapHigh |=> $stable(holdQ));
  // R10: result only moves on a latch
  a_r10_result_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.latchPeak || ctl.latchRaw) |=> $stable(resultQ));
endmodule

// File: rtl/pcm_level_meter.sv
module pcm_level_meter
  import pcm_level_meter_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int COUNT_W  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameTick,
  input  logic [SAMPLE_W-1:0]   sampleIn,
  input  logic                  countWr,
  input  logic [COUNT_W-1:0]    countData,
  input  logic                  readLow,
  input  logic                  readHigh,
  output logic [SAMPLE_W/2-1:0] lowByte,
  output logic [SAMPLE_W/2-1:0] highByte
);
  localparam int HALF = SAMPLE_W / 2;

  meterCtl_t           ctl;
  logic                ready;
  logic [SAMPLE_W-1:0] resultQ;

  pcm_level_meter_ctrl #(.COUNT_W(COUNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .countWr(countWr),
    .countData(countData), .readLow(readLow), .readHigh(readHigh),
    .ctl(ctl), .ready(ready)
  );

  pcm_level_meter_dp #(.SAMPLE_W(SAMPLE_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleIn(sampleIn),
    .resultQ(resultQ), .holdQ(highByte)
  );

  assign lowByte = {resultQ[HALF-1:1], ready};
endmodule

// File: tb/pcm_level_meter_test.sv
module pcm_level_meter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameTick = 1'b0;
  logic [15:0] sampleIn = '0;
  logic        countWr = 1'b0;
  logic [7:0]  countData = '0;
  logic        readLow = 1'b0;
  logic        readHigh = 1'b0;
  logic [7:0]  lowByte, highByte;

  int checks = 0;
  int fails = 0;
  string tag = "R1";

  // reference model state
  logic [7:0]  mCount = '0;
  logic [7:0]  mFc = '0;
  logic [15:0] mPeak = '0;
  logic [15:0] mRes = '0;
  logic [7:0]  mHold = '0;
  logic        mReady = 1'b0;

  pcm_level_meter uut (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .sampleIn(sampleIn),
    .countWr(countWr), .countData(countData), .readLow(readLow),
    .readHigh(readHigh), .lowByte(lowByte), .highByte(highByte)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] magOf(input logic [15:0] s);
    return s[15] ? (~s + 16'd1) : s;
  endfunction

  task automatic compare();
    logic [7:0] expLow;
    expLow = {mRes[7:1], mReady};
    checks++;
    if (lowByte !== expLow || highByte !== mHold) begin
      fails++;
      $display("FAIL %s: low=%h high=%h expected low=%h high=%h",
               tag, lowByte, highByte, expLow, mHold);
    end
  endtask

  // one clock with the given strobes; model updated from pre-edge state
  task automatic cycle(input logic ft, input logic [15:0] s, input logic cw,
                       input logic [7:0] cd, input logic rl, input logic rh);
    logic lat;
    logic [15:0] pk;
    frameTick = ft; sampleIn = s; countWr = cw; countData = cd;
    readLow = rl; readHigh = rh;
    @(posedge clk);
    #1;
    lat = 1'b0;
    if (rl) mHold = mRes[15:8];
    if (cw) begin
      mCount = cd; mFc = '0; mPeak = '0;
    end else if (ft) begin
      if (mCount == 0) begin
        mRes = s; lat = 1'b1;
      end else begin
        pk = (magOf(s) > mPeak) ? magOf(s) : mPeak;
        if (mFc == mCount - 8'd1) begin
          mRes = pk; lat = 1'b1; mPeak = '0; mFc = '0;
        end else begin
          mPeak = pk; mFc = mFc + 8'd1;
        end
      end
    end
    if (lat) mReady = 1'b1;
    else if (rh) mReady = 1'b0;
    frameTick = 0; countWr = 0; readLow = 0; readHigh = 0;
    compare();
  endtask

  task automatic frame(input logic [15:0] s);
    cycle(1, s, 0, 8'd0, 0, 0);
  endtask

  task automatic setCount(input logic [7:0] n);
    cycle(0, 16'd0, 1, n, 0, 0);
  endtask

  task automatic readPair();
    cycle(0, 16'd0, 0, 8'd0, 1, 0);
    cycle(0, 16'd0, 0, 8'd0, 0, 1);
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tag = "R1"; compare();

    tag = "R5";
    frame(16'hA5C3); readPair();
    frame(16'h8001); frame(16'h7FFE); readPair();

    tag = "R3";
    setCount(8'd1);
    frame(16'hFFF0); frame(16'h0123); readPair();
    setCount(8'd3);
    frame(16'h0010); frame(16'h0400); cycle(0, 0, 0, 0, 0, 0);
    frame(16'h0002); readPair();

    tag = "R4";
    setCount(8'd2);
    frame(16'h8000); frame(16'h7FFF); readPair();
    frame(16'hFF01); frame(16'h00FE); readPair();

    tag = "R9";
    frame(16'h1234); frame(16'h0001);
    frame(16'h0002); frame(16'h0003); readPair();

    tag = "R7";
    frame(16'h0555);
    cycle(1, 16'h0066, 0, 8'd0, 0, 1);
    cycle(0, 0, 0, 0, 0, 1);

    tag = "R2";
    setCount(8'd4);
    frame(16'h7000); frame(16'h7000);
    cycle(1, 16'h7FFF, 1, 8'd2, 0, 0);
    frame(16'h0011); frame(16'h0022); readPair();

    tag = "R8";
    readPair();
    frame(16'h3300); frame(16'h0000);
    cycle(0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 1, 0);

    tag = "R10";
    repeat (5) cycle(0, 16'hFFFF, 0, 8'd0, 0, 0);

    tag = "R6";
    setCount(8'd255);
    for (int i = 0; i < 255; i++) frame(16'(i * 97));
    readPair();

    tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3)
        cycle($urandom_range(0, 1), 16'($urandom), 1,
              8'($urandom_range(0, 6)), 0, 0);
      else
        cycle(r < 55, 16'($urandom), 0, 8'd0,
              $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule